// File: doc/BRIEF.md
# Reference Clock Selector with Holdover

This block picks the timing source for a system from three candidates: a primary external reference, a secondary external reference and an internal free-running oscillator. Both external references arrive as single-cycle tick strobes that are already synchronized to the local clock. A shared window timer cuts local time into fixed windows. One frequency monitor per reference counts the ticks in each window and compares the count with a programmable nominal value and a programmable tolerance. The monitors apply hysteresis: a reference is declared failed quickly and declared healthy again only after a longer run of good windows.

The selection logic runs in automatic mode by default. In that mode it always uses the best healthy source in the order primary, secondary, internal. A returning primary is therefore taken back as soon as its monitor reports it healthy. A user command can pin the selection to a chosen source. The pin holds until that source fails, and the logic then drops back into automatic mode. Commands and monitor-driven changes go through one shared next-state path. The chosen source appears as a registered 2-bit select code, which stands in for a glitch-free clock multiplexer. Each change of that code comes with a one-cycle event pulse.

Top module: `refclk_selector`

## Requirements
- R1: While reset is held and in the first cycle after it, `sel_out` is 2'b10 (internal), `switch_evt` is 0, `cmd_err` is 0 and `health` is 2'b00.
- R2: A monitor counts the ticks seen in each window of WIN_LEN local cycles. The window is good when the absolute difference between that count and `cfg_nominal` is at most `cfg_limit`; a difference of exactly `cfg_limit` is still good.
- R3: A healthy reference is declared failed after FAIL_WINS consecutive bad windows (default 2). `health[0]` is the primary and `health[1]` the secondary, and 1 means healthy.
- R4: A failed reference is declared healthy only after GOOD_WINS consecutive good windows (default 8). A bad window restarts that run.
- R5: In automatic mode the selection is the primary (2'b00) when it is healthy, otherwise the secondary (2'b01) when it is healthy, otherwise internal (2'b10). This makes the logic fall over from a failed primary to a healthy secondary.
- R6: Whenever neither reference is healthy, the selection is internal (2'b10) from the next cycle on.
- R7: In automatic mode a primary that has become healthy again is selected automatically, whatever the current selection is.
- R8: When `cmd_valid` is high, `cmd_sel` names a target (00 primary, 01 secondary, 10 internal). The command is accepted when the target is healthy; internal is always accepted. An accepted secondary or internal command pins the selection. The pin holds until the pinned reference fails, and the logic then returns to automatic mode. An accepted primary command returns the logic to automatic mode.
- R9: A command whose target is unhealthy, or whose code is 2'b11, leaves the selection unchanged and sets `cmd_err`. `cmd_err` stays set until reset.
- R10: `switch_evt` is high for exactly the first cycle in which `sel_out` shows a new value, and it is low in every other cycle. A command that names the current source causes no event.
- R11: `sel_out` only ever takes the values 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_tick | input | 1 | One-cycle strobe for each primary reference edge |
| sec_tick | input | 1 | One-cycle strobe for each secondary reference edge |
| cfg_nominal | input | CNT_W | Expected tick count per window |
| cfg_limit | input | CNT_W | Allowed deviation from the nominal count |
| cmd_valid | input | 1 | User selection command strobe |
| cmd_sel | input | 2 | Command target code |
| sel_out | output | 2 | Selected source: 00 primary, 01 secondary, 10 internal |
| switch_evt | output | 1 | One-cycle pulse with each change of sel_out |
| health | output | 2 | Health of the references: bit 0 primary, bit 1 secondary |
| cmd_err | output | 1 | Sticky flag for a rejected command |

## Verification
The bench targets the hysteresis counts. A monitor that failed after a single bad window would leave the primary in the first 20 cycles after its ticks stop. One that recovered too early would take the primary back while the bench still expects internal. The tolerance edge is checked by moving the nominal count so that the deviation is exactly the limit and then one more. An off-by-one comparison would either drop a healthy reference or keep a bad one. Pinned commands, rejected commands and redundant commands are scored by the event queue: any extra, missing or wrong switch event shows up as a mismatch or as a leftover queue entry.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    SEL_PRI = 2'b00,
    SEL_SEC = 2'b01,
    SEL_INT = 2'b10
  } sel_e;
endpackage

// File: rtl/refsel_win_timer.sv
module refsel_win_timer #(
  parameter int WIN_LEN = 4096
) (
  input  logic clk,
  input  logic rst,
  output logic win_end
);
  localparam int TW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

  logic [TW-1:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else if (cyc_q == LAST) cyc_q <= '0;
    else cyc_q <= cyc_q + 1'b1;
  end

  assign win_end = (cyc_q == LAST);
endmodule

// File: rtl/refsel_freq_mon.sv
module refsel_freq_mon #(
  parameter int CNT_W     = 16,
  parameter int FAIL_WINS = 2,
  parameter int GOOD_WINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             win_end,
  input  logic [CNT_W-1:0] nominal,
  input  logic [CNT_W-1:0] limit,
  output logic             healthy
);
  localparam int RUN_MAX = (FAIL_WINS > GOOD_WINS) ? FAIL_WINS : GOOD_WINS;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] FAIL_LAST = RUN_W'(FAIL_WINS - 1);
  localparam logic [RUN_W-1:0] GOOD_LAST = RUN_W'(GOOD_WINS - 1);

  logic [CNT_W-1:0] tally_q;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] dev;
  logic             bad_win;
  logic [RUN_W-1:0] run_q;
  logic             ok_q;

  // Count of the closing window includes a tick arriving in its last cycle
  always_comb begin
    total   = tally_q + {{(CNT_W-1){1'b0}}, tick};
    dev     = (total >= nominal) ? (total - nominal) : (nominal - total);
    bad_win = (dev > limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tally_q <= '0;
      run_q   <= '0;
      ok_q    <= 1'b0;
    end else if (win_end) begin
      tally_q <= '0;
      if (ok_q) begin
        if (!bad_win) run_q <= '0;
        else if (run_q == FAIL_LAST) begin
          ok_q  <= 1'b0;
          run_q <= '0;
        end else run_q <= run_q + 1'b1;
      end else begin
        if (bad_win) run_q <= '0;
        else if (run_q == GOOD_LAST) begin
          ok_q  <= 1'b1;
          run_q <= '0;
        end else run_q <= run_q + 1'b1;
      end
    end else begin
      tally_q <= total;
    end
  end

  assign healthy = ok_q;
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pri_ok,
  input  logic       sec_ok,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_sel,
  output logic [1:0] sel,
  output logic       evt,
  output logic       err
);
  sel_e sel_q, sel_n;
  logic pinned_q, pinned_n;
  logic err_q, err_n;
  logic evt_q;

  function automatic sel_e best_src(input logic p_ok, input logic s_ok);
    if (p_ok) return SEL_PRI;
    if (s_ok) return SEL_SEC;
    return SEL_INT;
  endfunction

  always_comb begin
    sel_n    = sel_q;
    pinned_n = pinned_q;
    err_n    = err_q;
    // user path
    if (cmd_valid) begin
      case (cmd_sel)
        2'b00: if (pri_ok) begin sel_n = SEL_PRI; pinned_n = 1'b0; end
               else err_n = 1'b1;
        2'b01: if (sec_ok) begin sel_n = SEL_SEC; pinned_n = 1'b1; end
               else err_n = 1'b1;
        2'b10: begin sel_n = SEL_INT; pinned_n = 1'b1; end
        default: err_n = 1'b1;
      endcase
    end
    // monitor path: a pinned source that failed drops back to automatic
    if ((sel_n == SEL_PRI && !pri_ok) || (sel_n == SEL_SEC && !sec_ok))
      pinned_n = 1'b0;
    if (!pinned_n) sel_n = best_src(pri_ok, sec_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_INT;
      pinned_q <= 1'b0;
      err_q    <= 1'b0;
      evt_q    <= 1'b0;
    end else begin
      sel_q    <= sel_n;
      pinned_q <= pinned_n;
      err_q    <= err_n;
      evt_q    <= (sel_n != sel_q);
    end
  end

  assign sel = sel_q;
  assign evt = evt_q;
  assign err = err_q;
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector #(
  parameter int WIN_LEN   = 4096,
  parameter int CNT_W     = 16,
  parameter int FAIL_WINS = 2,
  parameter int GOOD_WINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pri_tick,
  input  logic             sec_tick,
  input  logic [CNT_W-1:0] cfg_nominal,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_sel,
  output logic [1:0]       sel_out,
  output logic             switch_evt,
  output logic [1:0]       health,
  output logic             cmd_err
);
  localparam int NREF = 2;

  logic            win_end;
  logic [NREF-1:0] ticks;
  logic [NREF-1:0] ok;

  assign ticks = {sec_tick, pri_tick};

  refsel_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk(clk), .rst(rst), .win_end(win_end)
  );

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    refsel_freq_mon #(
      .CNT_W(CNT_W), .FAIL_WINS(FAIL_WINS), .GOOD_WINS(GOOD_WINS)
    ) u_mon (
      .clk(clk), .rst(rst), .tick(ticks[g]), .win_end(win_end),
      .nominal(cfg_nominal), .limit(cfg_limit), .healthy(ok[g])
    );
  end

  refsel_fsm u_fsm (
    .clk(clk), .rst(rst), .pri_ok(ok[0]), .sec_ok(ok[1]),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .sel(sel_out), .evt(switch_evt), .err(cmd_err)
  );

  assign health = ok;
endmodule

// File: rtl/refclk_selector_chk.sv
module refclk_selector_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sel_out,
  input logic       switch_evt,
  input logic [1:0] health,
  input logic       cmd_err
);
  assert_legal_code_R11: assert property (@(posedge clk) disable iff (rst)
    sel_out != 2'b11);

  assert_evt_means_change_R10: assert property (@(posedge clk) disable iff (rst)
    switch_evt |-> (sel_out != $past(sel_out)));

  assert_change_means_evt_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_out != $past(sel_out)) |-> switch_evt);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_err) |-> cmd_err);

  assert_none_healthy_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(health) == 2'b00) |-> (sel_out == 2'b10));

  assert_leave_failed_pri_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(sel_out) == 2'b00 && !$past(health[0])) |-> (sel_out != 2'b00));

  assert_enter_needs_health_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_out == 2'b01 && $past(sel_out) != 2'b01) |-> $past(health[1]));
endmodule

bind refclk_selector refclk_selector_chk u_chk (
  .clk(clk), .rst(rst), .sel_out(sel_out), .switch_evt(switch_evt),
  .health(health), .cmd_err(cmd_err)
);

// File: tb/refclk_selector_tb_top.sv
module refclk_selector_tb_top;
  localparam int WIN = 32;
  localparam int CW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pri_tick = 1'b0, sec_tick = 1'b0;
  logic [CW-1:0] cfg_nominal = 8'd8, cfg_limit = 8'd1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_sel = 2'b00;
  logic [1:0]    sel_out;
  logic          switch_evt;
  logic [1:0]    health;
  logic          cmd_err;

  int checks = 0, errors = 0;
  int pri_per = 0, sec_per = 0;
  int pri_ph = 0, sec_ph = 0;
  logic [1:0] exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  refclk_selector #(.WIN_LEN(WIN), .CNT_W(CW), .FAIL_WINS(2), .GOOD_WINS(8)) dut_i (
    .clk(clk), .rst(rst), .pri_tick(pri_tick), .sec_tick(sec_tick),
    .cfg_nominal(cfg_nominal), .cfg_limit(cfg_limit),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .sel_out(sel_out), .switch_evt(switch_evt), .health(health), .cmd_err(cmd_err)
  );

  // reference tick generators (period 0 = dead reference)
  always @(negedge clk) begin
    if (pri_per == 0) pri_tick <= 1'b0;
    else begin pri_ph = (pri_ph + 1) % pri_per; pri_tick <= (pri_ph == 0); end
    if (sec_per == 0) sec_tick <= 1'b0;
    else begin sec_ph = (sec_ph + 1) % sec_per; sec_tick <= (sec_ph == 0); end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] s);
    exp_q.push_back(s);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_cyc(2);
  endtask

  // scoreboard monitor: every switch event must match the next expected select
  always @(negedge clk) begin
    if (!rst && switch_evt) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R10 unexpected switch event", int'(sel_out), -1);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(sel_out == e, "R10 switch event select", int'(sel_out), int'(e));
      end
    end
  end

  initial begin
    wait_cyc(150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk(sel_out == 2'b10 && !switch_evt, "R1 reset select", int'(sel_out), 2);
    chk(cmd_err == 1'b0 && health == 2'b00, "R1 reset status", int'({cmd_err, health}), 0);
    @(negedge clk); rst = 1'b0;
    chk(sel_out == 2'b10 && !switch_evt, "R1 first cycle after reset", int'(sel_out), 2);

    // both references start at nominal rate: 8 ticks per 32-cycle window
    push_exp(2'b00);
    pri_per = 4; sec_per = 4;
    wait_cyc(12 * WIN);
    chk(health == 2'b11, "R4 both recovered", int'(health), 3);
    chk(sel_out == 2'b00, "R7 automatic primary", int'(sel_out), 0);

    // redundant command: no event
    send_cmd(2'b00);
    chk(sel_out == 2'b00, "R10 redundant command", int'(sel_out), 0);

    // pinned secondary holds despite healthy primary
    push_exp(2'b01);
    send_cmd(2'b01);
    wait_cyc(3 * WIN);
    chk(sel_out == 2'b01, "R8 pinned secondary", int'(sel_out), 1);

    // pinned internal, then back to primary
    push_exp(2'b10);
    send_cmd(2'b10);
    wait_cyc(2 * WIN);
    chk(sel_out == 2'b10, "R8 pinned internal", int'(sel_out), 2);
    push_exp(2'b00);
    send_cmd(2'b00);
    chk(sel_out == 2'b00, "R8 command primary", int'(sel_out), 0);

    // reserved code ignored
    send_cmd(2'b11);
    chk(sel_out == 2'b00, "R9 reserved code ignored", int'(sel_out), 0);
    chk(cmd_err == 1'b1, "R9 reserved code error", int'(cmd_err), 1);

    // primary dies: at most one window boundary within 20 cycles
    push_exp(2'b01);
    pri_per = 0;
    wait_cyc(20);
    chk(sel_out == 2'b00 && health[0], "R3 one bad window tolerated", int'(sel_out), 0);
    wait_cyc(4 * WIN);
    chk(health == 2'b10, "R3 primary failed", int'(health), 2);
    chk(sel_out == 2'b01, "R5 fallover to secondary", int'(sel_out), 1);

    // command to failed primary ignored
    send_cmd(2'b00);
    chk(sel_out == 2'b01, "R9 failed target ignored", int'(sel_out), 1);
    chk(cmd_err == 1'b1, "R9 error sticky", int'(cmd_err), 1);

    // secondary dies too
    push_exp(2'b10);
    sec_per = 0;
    wait_cyc(4 * WIN);
    chk(health == 2'b00, "R3 secondary failed", int'(health), 0);
    chk(sel_out == 2'b10, "R6 internal fallback", int'(sel_out), 2);

    // primary returns: not before 8 good windows
    push_exp(2'b00);
    pri_per = 4;
    wait_cyc(4 * WIN);
    chk(sel_out == 2'b10 && !health[0], "R4 no early recovery", int'(sel_out), 2);
    wait_cyc(8 * WIN);
    chk(health == 2'b01, "R4 primary recovered", int'(health), 1);
    chk(sel_out == 2'b00, "R7 revert to primary", int'(sel_out), 0);

    // tolerance boundary: deviation equal to limit stays healthy
    cfg_nominal = 8'd9;
    wait_cyc(5 * WIN);
    chk(health[0] && sel_out == 2'b00, "R2 deviation at limit good", int'(health), 1);
    // deviation of limit+1 is bad
    push_exp(2'b10);
    cfg_nominal = 8'd10;
    wait_cyc(5 * WIN);
    chk(health == 2'b00, "R2 deviation over limit bad", int'(health), 0);
    chk(sel_out == 2'b10, "R6 internal after out-of-tolerance", int'(sel_out), 2);

    wait_cyc(4);
    chk(exp_q.size() == 0, "R10 all expected events seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule